// File: doc/BRIEF.md
# Bit-Serial and Byte-Lane CRC-8 Unit

This block accumulates an 8-bit cyclic redundancy check over a stream of data. It uses the polynomial x^8 + x^5 + x^4 + 1 in its reflected form, so the data enters least-significant bit first. The caller clears the register, streams a block through it and then reads the check byte to append. A typical block is eight register bytes, or the 56 leading bits of an identity code. To confirm a received block, the caller streams the data and then the received check byte, and reads the zero flag. A clean block leaves an all-zero remainder.

The unit has two input streams. A one-bit stream advances the register by one step per accepted transfer. An optional lane of `LANE_W` bits advances it by `LANE_W` serial steps in a single cycle, least-significant bit first. Framing and byte counting stay with the caller.

Both input streams use valid/ready handshaking. A transfer happens on a rising edge where valid and ready are both high.
- The lane stream is ready whenever `clear` is low.
- The bit stream is ready only when `clear` is low and the lane is not presenting data.
- A producer facing low ready must hold its data until ready returns.
- Data presented while ready is low is not consumed.

Top module: `crc8_stream_unit`

## Requirements
- R1: One step computes fb = crc[0] XOR d. The register then shifts right by one, and if fb is 1 it is XORed with 8'h8C. This is x^8+x^5+x^4+1 taken LSB first.
- R2: When `clear` is high at a rising edge, the register becomes 8'h00 after that edge and `zero` reads 1. The same holds after reset.
- R3: `clear` takes priority over both streams. While `clear` is high, `bit_ready` and `byte_ready` are both low, and any offered bit or lane word is dropped.
- R4: When a bit is accepted, `crc_out` shows the result of one R1 step after the same edge.
- R5: When a lane word is accepted, `crc_out` shows the result of `LANE_W` R1 steps after the same edge. The steps take bit 0 of `byte_in` first.
- R6: When `byte_valid` and `bit_valid` are both high and `clear` is low, only the lane word is consumed. `bit_ready` is low and the bit is left untouched.
- R7: In a cycle with no accepted transfer and no clear, `crc_out` keeps its value.
- R8: `zero` is 1 exactly when `crc_out` is 8'h00. After a block is followed by its own check byte (LSB first), `zero` reads 1. A single flipped data bit leaves `zero` at 0.
- R9: Starting from clear, the bytes 8'h31 through 8'h39 yield a check byte of 8'hA1 on either input stream.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| clear | input | 1 | Restart the register at zero before a block |
| bit_valid | input | 1 | A serial bit is offered |
| bit_ready | output | 1 | The serial bit will be taken at this edge |
| bit_in | input | 1 | Serial data bit |
| byte_valid | input | 1 | A lane word is offered |
| byte_ready | output | 1 | The lane word will be taken at this edge |
| byte_in | input | LANE_W | Lane data word; bit 0 is processed first |
| crc_out | output | 8 | Current remainder / check byte |
| zero | output | 1 | High when the remainder is all zeros |

## Verification
Both ready outputs depend only on the current inputs, so they are valid in the same cycle the stimulus is applied. `crc_out` and `zero` change one rising edge after a transfer or a clear is accepted.

The bench drives every input on the falling edge. It checks the ready outputs 1 ns after driving. For each stimulus it queues the expected remainder. A monitor takes each queued item 5 ns after the next rising edge and compares it against `crc_out` and `zero`. The expected values come from a software model that applies the R1 step bit by bit.

// File: rtl/crc8_pkg.sv
package crc8_pkg;
  localparam int CRC_W = 8;
  typedef logic [CRC_W-1:0] crc_t;
  typedef enum logic [1:0] {
    SRC_NONE  = 2'd0,
    SRC_BIT   = 2'd1,
    SRC_LANE  = 2'd2,
    SRC_CLEAR = 2'd3
  } src_e;
endpackage

// File: rtl/crc8_bit_step.sv
// One reflected LFSR step (R1).
module crc8_bit_step #(
  parameter int          CRC_W = 8,
  parameter logic [CRC_W-1:0] POLY = 8'h8C
) (
  input  logic [CRC_W-1:0] crc_i,
  input  logic             d_i,
  output logic [CRC_W-1:0] crc_o
);
  logic fb;
  always_comb begin
    fb    = crc_i[0] ^ d_i;
    crc_o = (crc_i >> 1) ^ (fb ? POLY : '0);
  end
endmodule

// File: rtl/crc8_lane_chain.sv
// LANE_W cascaded steps, bit 0 of the word first (R5).
module crc8_lane_chain #(
  parameter int          CRC_W  = 8,
  parameter int          LANE_W = 8,
  parameter logic [CRC_W-1:0] POLY = 8'h8C
) (
  input  logic [CRC_W-1:0]  crc_i,
  input  logic [LANE_W-1:0] word_i,
  output logic [CRC_W-1:0]  crc_o
);
  logic [CRC_W-1:0] stage [LANE_W+1];

  assign stage[0] = crc_i;

  for (genvar i = 0; i < LANE_W; i++) begin : g_step
    crc8_bit_step #(.CRC_W(CRC_W), .POLY(POLY)) u_step (
      .crc_i (stage[i]),
      .d_i   (word_i[i]),
      .crc_o (stage[i+1])
    );
  end

  assign crc_o = stage[LANE_W];
endmodule

// File: rtl/crc8_src_arb.sv
// Source priority: clear, then lane, then bit (R3, R6).
module crc8_src_arb
  import crc8_pkg::*;
#(
  parameter bit HAS_LANE = 1'b1
) (
  input  logic clear,
  input  logic bit_valid,
  input  logic byte_valid,
  output logic bit_ready,
  output logic byte_ready,
  output src_e sel
);
  logic lane_req;
  assign lane_req = HAS_LANE && byte_valid;

  always_comb begin
    byte_ready = HAS_LANE && !clear;
    bit_ready  = !clear && !lane_req;
    if (clear)                       sel = SRC_CLEAR;
    else if (lane_req)               sel = SRC_LANE;
    else if (bit_valid)              sel = SRC_BIT;
    else                             sel = SRC_NONE;
  end
endmodule

// File: rtl/crc8_stream_unit.sv
module crc8_stream_unit
  import crc8_pkg::*;
#(
  parameter int               LANE_W   = 8,
  parameter bit               HAS_LANE = 1'b1,
  parameter logic [CRC_W-1:0] POLY     = 8'h8C
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              bit_valid,
  output logic              bit_ready,
  input  logic              bit_in,
  input  logic              byte_valid,
  output logic              byte_ready,
  input  logic [LANE_W-1:0] byte_in,
  output logic [CRC_W-1:0]  crc_out,
  output logic              zero
);
  crc_t crc_q, crc_bit_nx, crc_lane_nx, crc_d;
  src_e sel;

  crc8_src_arb #(.HAS_LANE(HAS_LANE)) u_arb (
    .clear      (clear),
    .bit_valid  (bit_valid),
    .byte_valid (byte_valid),
    .bit_ready  (bit_ready),
    .byte_ready (byte_ready),
    .sel        (sel)
  );

  crc8_bit_step #(.CRC_W(CRC_W), .POLY(POLY)) u_bit (
    .crc_i (crc_q),
    .d_i   (bit_in),
    .crc_o (crc_bit_nx)
  );

  if (HAS_LANE) begin : g_lane
    crc8_lane_chain #(.CRC_W(CRC_W), .LANE_W(LANE_W), .POLY(POLY)) u_lane (
      .crc_i  (crc_q),
      .word_i (byte_in),
      .crc_o  (crc_lane_nx)
    );
  end else begin : g_no_lane
    assign crc_lane_nx = crc_q;
  end

  always_comb begin
    unique case (sel)
      SRC_CLEAR: crc_d = '0;
      SRC_LANE:  crc_d = crc_lane_nx;
      SRC_BIT:   crc_d = crc_bit_nx;
      default:   crc_d = crc_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) crc_q <= '0;
    else        crc_q <= crc_d;
  end

  assign crc_out = crc_q;
  assign zero    = (crc_q == '0);

  // Assertions
  p_clear_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> (crc_out == '0) && zero);

  p_clear_blocks_r3: assert property (@(posedge clk) disable iff (!rst_n)
    clear |-> !bit_ready && !byte_ready);

  p_lane_wins_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (HAS_LANE && byte_valid && !clear) |-> !bit_ready);

  p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!clear && !bit_valid && !byte_valid) |=> $stable(crc_out));

  // A bit equal to crc[0] produces no feedback, so the step is a plain shift.
  p_bit_shift_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!clear && bit_valid && bit_ready && bit_in == crc_out[0])
      |=> crc_out == ($past(crc_out) >> 1));

  if (HAS_LANE && LANE_W == CRC_W) begin : g_res_chk
    // Feeding the remainder itself as a lane word must leave zero residue.
    p_residue_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (!clear && byte_valid && byte_in == crc_out) |=> zero);
  end
endmodule

// File: tb/sim_crc8_stream_unit.sv
`timescale 1ns/1ps
module sim_crc8_stream_unit;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       clear = 1'b0, bit_valid = 1'b0, bit_in = 1'b0, byte_valid = 1'b0;
  logic [7:0] byte_in = 8'h00;
  logic       bit_ready, byte_ready, zero;
  logic [7:0] crc_out;

  int n_run = 0;
  int n_fail = 0;

  typedef struct {
    logic [7:0] crc;
    string      tag;
  } exp_t;
  exp_t q[$];
  logic [7:0] model = 8'h00;

  always #10 clk = ~clk;

  crc8_stream_unit u0 (
    .clk(clk), .rst_n(rst_n), .clear(clear),
    .bit_valid(bit_valid), .bit_ready(bit_ready), .bit_in(bit_in),
    .byte_valid(byte_valid), .byte_ready(byte_ready), .byte_in(byte_in),
    .crc_out(crc_out), .zero(zero)
  );

  // Reference model of the R1 step (R1).
  function automatic logic [7:0] m_bit(input logic [7:0] c, input logic d);
    logic x;
    x = c[0] ^ d;
    c = c >> 1;
    if (x) c = c ^ 8'h8C;
    return c;
  endfunction

  function automatic logic [7:0] m_byte(input logic [7:0] c, input logic [7:0] w);
    for (int i = 0; i < 8; i++) c = m_bit(c, w[i]);
    return c;
  endfunction

  task automatic check(input bit ok, input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Driver: apply one cycle of stimulus, check ready, queue expected result.
  task automatic step(input logic clr, input logic bv, input logic b,
                      input logic yv, input logic [7:0] y, input string tag);
    exp_t it;
    logic exp_br, exp_yr;
    @(negedge clk);
    clear = clr; bit_valid = bv; bit_in = b; byte_valid = yv; byte_in = y;
    #1;
    exp_br = !clr && !yv;
    exp_yr = !clr;
    check(bit_ready == exp_br && byte_ready == exp_yr, {tag, " ready"},
          {6'b0, bit_ready, byte_ready}, {6'b0, exp_br, exp_yr});
    if (clr)     model = 8'h00;
    else if (yv) model = m_byte(model, y);
    else if (bv) model = m_bit(model, b);
    it.crc = model;
    it.tag = tag;
    q.push_back(it);
  endtask

  task automatic idle_drive();
    @(negedge clk);
    clear = 0; bit_valid = 0; byte_valid = 0;
  endtask

  task automatic send_bits(input logic [7:0] w, input string tag);
    for (int i = 0; i < 8; i++) step(0, 1, w[i], 0, 8'h00, tag);
  endtask

  // Monitor: result is due one rising edge after the stimulus.
  always @(posedge clk) begin
    #5;
    if (q.size() > 0) begin
      exp_t it;
      it = q.pop_front();
      check(crc_out == it.crc && zero == (it.crc == 8'h00), it.tag,
            crc_out, it.crc);
    end
  end

  initial begin : watchdog
    #(200000 * 20);
    n_fail++;
    $display("FAIL watchdog expired actual=%h expected=%h", 8'h00, 8'h01);
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    logic [7:0] id [7];
    logic [7:0] rem;
    repeat (3) @(negedge clk);
    check(crc_out == 8'h00 && zero == 1'b1, "R2 reset state", crc_out, 8'h00);
    rst_n = 1'b1;

    // R2: clear
    step(0, 1, 1, 0, 8'h00, "R4 bit before clear");
    step(1, 0, 0, 0, 8'h00, "R2 clear");

    // R4/R9: serial pass over 0x31..0x39
    for (int k = 0; k < 9; k++) send_bits(8'h31 + 8'(k), "R4 serial bits");
    idle_drive();
    repeat (2) @(negedge clk);
    check(crc_out == 8'hA1, "R9 serial check value", crc_out, 8'hA1);

    // R8: append check byte serially -> zero residue
    send_bits(8'hA1, "R8 serial residue");
    idle_drive();
    repeat (2) @(negedge clk);
    check(zero == 1'b1, "R8 zero after serial check byte", {7'b0, zero}, 8'h01);

    // R5/R9: lane pass
    step(1, 0, 0, 0, 8'h00, "R2 clear before lane");
    for (int k = 0; k < 9; k++) step(0, 0, 0, 1, 8'h31 + 8'(k), "R5 lane word");
    idle_drive();
    repeat (2) @(negedge clk);
    check(crc_out == 8'hA1, "R9 lane check value", crc_out, 8'hA1);
    step(0, 0, 0, 1, 8'hA1, "R8 lane residue");

    // R7: hold
    step(0, 0, 1, 0, 8'h5A, "R7 hold idle 1");
    step(0, 0, 0, 0, 8'hFF, "R7 hold idle 2");

    // R3: clear beats both streams
    step(0, 0, 0, 1, 8'h77, "R5 lane word 77");
    step(1, 1, 1, 1, 8'h3C, "R3 clear wins");

    // R6: lane wins over bit
    step(0, 0, 0, 1, 8'hC4, "R5 lane word C4");
    step(0, 1, 1, 1, 8'h19, "R6 lane over bit");
    step(0, 1, 0, 1, 8'hE2, "R6 lane over bit 2");
    step(0, 1, 1, 0, 8'h00, "R4 lone bit after lane");

    // R8: identity-style 56-bit code, mixed streams, own check byte appended
    id = '{8'h3B, 8'h12, 8'h9F, 8'h00, 8'hC7, 8'h45, 8'hEE};
    step(1, 0, 0, 0, 8'h00, "R2 clear before identity");
    for (int k = 0; k < 7; k++) begin
      if (k[0]) send_bits(id[k], "R4 identity bits");
      else      step(0, 0, 0, 1, id[k], "R5 identity word");
    end
    rem = model;
    send_bits(rem, "R8 identity residue");
    idle_drive();
    repeat (2) @(negedge clk);
    check(zero == 1'b1, "R8 identity zero", {7'b0, zero}, 8'h01);

    // R8: single flipped bit is detected
    step(1, 0, 0, 0, 8'h00, "R2 clear before error");
    for (int k = 0; k < 7; k++)
      step(0, 0, 0, 1, (k == 3) ? (id[k] ^ 8'h10) : id[k], "R5 corrupted word");
    step(0, 0, 0, 1, rem, "R8 corrupted residue");
    idle_drive();
    repeat (2) @(negedge clk);
    check(zero == 1'b0, "R8 error not zero", {7'b0, zero}, 8'h00);

    // R1: single steps from a known state
    step(1, 0, 0, 0, 8'h00, "R2 clear before R1");
    step(0, 1, 1, 0, 8'h00, "R1 step feedback");
    step(0, 1, 0, 0, 8'h00, "R1 step shift");
    idle_drive();
    repeat (2) @(negedge clk);
    check(crc_out == 8'h46, "R1 two-step value", crc_out, 8'h46);

    repeat (3) @(negedge clk);
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule